// File: doc/BRIEF.md
# I2C Controller Register and Event Front End

This block is the software-visible face of a byte-oriented I2C master. It sits between a 32-bit memory-mapped bus and two neighbouring blocks, the bus protocol engine and the SCL divider. It holds eight byte-wide registers, one per 32-bit word, and hands their contents to the engine and the divider. It also gathers the condition pulses that the engine raises into sticky status flags.

A driver programs the control, clock and own-address registers, moves bytes through the data register and watches two status registers. Every pending condition feeds a single summary event flag, and one level interrupt follows that flag when interrupts are enabled. Each flag is cleared by the register access that naturally consumes it: moving a data byte, rewriting the control register, or reading the error register. A driver therefore rarely needs an explicit acknowledge write.

Top module: `i2c_reg_front`

## Requirements
- R1: After reset every register reads 0x00 except own-address 2 (offset 0x14), which reads 0x40. irq_o is 0 and bus_rdata_o is 0.
- R2: A read of a mapped word offset returns the 8-bit register value in every byte lane of bus_rdata_o in the cycle after the request. A write takes only bits [7:0]. Offsets are 0x00 control, 0x04 status 1, 0x08 status 2, 0x0C clock, 0x10 own address 1, 0x14 own address 2, 0x18 data and 0x1C extended clock. At most one register strobe is active in a cycle.
- R3: An access to an offset at or above 0x20, or to an offset not a multiple of 4, changes nothing. A read of such an offset returns 0 and clears no flag.
- R4: Status 1 is, MSB to LSB: event flag, 10-bit header (eng_evt_i[2]), eng_tx_mode_i, eng_busy_i, byte finished (eng_evt_i[3] or a received byte), address hit (eng_evt_i[1]), eng_master_i, start generated (eng_evt_i[0]).
- R5: Status 2 is, MSB to LSB: SCL falling (eng_evt_i[9]), reserved bit read as 0, end of address (eng_evt_i[4]), ack failure (eng_evt_i[5]), stop seen (eng_evt_i[6]), arbitration lost (eng_evt_i[7]), bus error (eng_evt_i[8]) and display-channel flag (eng_evt_i[10]).
- R6: The event flag (status 1 bit 7) is 1 exactly while any sticky flag in status 1 or status 2 is set.
- R7: irq_o is 1 exactly while the event flag and control bit 0 (interrupt enable) are both 1.
- R8: Reading the data register clears only the received-byte flag. Writing the data register clears the transmitted-byte, start-generated and 10-bit header flags.
- R9: A control write with bit 5 (peripheral enable) set clears the end-of-address flag. A control write with bit 5 clear clears every sticky flag.
- R10: Reading status 2 returns its value from before the read, then clears every status 2 flag except end of address.
- R11: A flag whose set pulse coincides with a clearing access stays set.
- R12: Writes to the two status registers are ignored.
- R13: div_o is {extended clock[4:0], clock[6:0]}, and fast_o is clock bit 7.
- R14: rx_valid_i loads rx_byte_i into the data register. A bus write to the data register makes tx_load_o high for the one following cycle, with tx_byte_o holding the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Access request this cycle |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data (low byte used) |
| bus_rdata_o | output | DATA_W | Read data, byte repeated in each lane |
| irq_o | output | 1 | Level interrupt |
| eng_evt_i | input | 11 | Condition pulses from the engine |
| eng_busy_i | input | 1 | Bus busy level |
| eng_tx_mode_i | input | 1 | Transmitter mode level |
| eng_master_i | input | 1 | Master mode level |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| ctl_o | output | 8 | Control register |
| div_o | output | 12 | SCL divider value |
| fast_o | output | 1 | Fast-mode select |
| own_addr1_o | output | 8 | Own address register 1 |
| own_addr2_o | output | 8 | Own address register 2 |
| tx_byte_o | output | 8 | Data register contents |
| tx_load_o | output | 1 | Data register written last cycle |

## Verification
The embedded properties check the following on every cycle: the level relation between the interrupt, the summary flag and the enable bit, that a set pulse beats a clear, the specific clears from data writes, status 2 reads and peripheral-enable writes, the loading of received bytes, one-hot register strobes, and zero data from unmapped reads. The directed scenarios cover what a single-cycle relation cannot show: exact bit layouts of both status registers, the value read out before a clear, lane replication, the reset image, and that an unmapped access, a status write or a data read leave the wrong flags untouched.

// File: rtl/i2c_front_pkg.sv
package i2c_front_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;

  // register index = word offset / 4
  localparam int RI_CTL  = 0;
  localparam int RI_ST1  = 1;
  localparam int RI_ST2  = 2;
  localparam int RI_CLK  = 3;
  localparam int RI_OWN1 = 4;
  localparam int RI_OWN2 = 5;
  localparam int RI_DATA = 6;
  localparam int RI_XCLK = 7;

  localparam int CTL_PE = 5;
  localparam int CTL_IE = 0;

  localparam int CLK_DIV_W  = 7;
  localparam int XCLK_DIV_W = 5;
  localparam int DIV_W      = CLK_DIV_W + XCLK_DIV_W;
  localparam int CLK_FAST   = 7;

  // engine condition pulse positions
  localparam int EV_START    = 0;
  localparam int EV_ADDR_HIT = 1;
  localparam int EV_HDR10    = 2;
  localparam int EV_TX_DONE  = 3;
  localparam int EV_ADDR_END = 4;
  localparam int EV_NACK     = 5;
  localparam int EV_STOP     = 6;
  localparam int EV_ARB      = 7;
  localparam int EV_BUSERR   = 8;
  localparam int EV_SCL_FALL = 9;
  localparam int EV_DDC      = 10;
  localparam int NUM_EVT_IN  = 11;
  localparam int FL_RX_DONE  = NUM_EVT_IN;
  localparam int NUM_FLAG    = NUM_EVT_IN + 1;

  localparam logic [REG_W-1:0] OWN2_RST = 8'h40;

  typedef logic [REG_W-1:0] reg_byte_t;

  function automatic reg_byte_t reg_reset(int idx);
    return (idx == RI_OWN2) ? OWN2_RST : '0;
  endfunction
endpackage

// File: rtl/i2c_front_decode.sv
module i2c_front_decode
  import i2c_front_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                bus_sel_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  output logic [NUM_REGS-1:0] wr_stb_o,
  output logic [NUM_REGS-1:0] rd_stb_o,
  output logic                mapped_o
);
  localparam int IDX_LSB = 2;
  localparam int IDX_W   = $clog2(NUM_REGS);
  localparam int SPAN    = IDX_LSB + IDX_W;

  logic [IDX_W-1:0] idx;

  assign idx      = bus_addr_i[SPAN-1:IDX_LSB];
  assign mapped_o = (bus_addr_i[IDX_LSB-1:0] == '0) &&
                    (bus_addr_i[ADDR_W-1:SPAN] == '0);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
    assign wr_stb_o[g] = bus_sel_i &  bus_wr_i & mapped_o & (idx == IDX_W'(g));
    assign rd_stb_o[g] = bus_sel_i & ~bus_wr_i & mapped_o & (idx == IDX_W'(g));
  end
endmodule

// File: rtl/i2c_front_cfg.sv
module i2c_front_cfg
  import i2c_front_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_REGS-1:0]             wr_stb_i,
  input  logic [REG_W-1:0]                wbyte_i,
  input  logic                            rx_valid_i,
  input  logic [REG_W-1:0]                rx_byte_i,
  output logic [NUM_REGS-1:0][REG_W-1:0]  regs_o,
  output logic [REG_W-1:0]                ctl_next_o
);
  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
  logic [NUM_REGS-1:0][REG_W-1:0] regs_d;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      regs_d[i] = regs_q[i];
      if (i == RI_ST1 || i == RI_ST2)
        regs_d[i] = '0;             // status lives in the event unit
      else if (wr_stb_i[i])
        regs_d[i] = wbyte_i;
      else if (i == RI_DATA && rx_valid_i)
        regs_d[i] = rx_byte_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_reset(i);
    end else begin
      regs_q <= regs_d;
    end
  end

  assign regs_o     = regs_q;
  assign ctl_next_o = regs_d[RI_CTL];

  p_rx_load_r14: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_i && !wr_stb_i[RI_DATA]) |=> (regs_q[RI_DATA] == $past(rx_byte_i)));
endmodule

// File: rtl/i2c_front_events.sv
module i2c_front_events
  import i2c_front_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_EVT_IN-1:0] evt_i,
  input  logic                  rx_valid_i,
  input  logic [NUM_REGS-1:0]   wr_stb_i,
  input  logic [NUM_REGS-1:0]   rd_stb_i,
  input  logic [REG_W-1:0]      wbyte_i,
  output logic [NUM_FLAG-1:0]   flags_o,
  output logic                  evf_o,
  output logic                  evf_next_o
);
  logic [NUM_FLAG-1:0] flag_q, flag_d, set_v, clr_v;
  logic pe_wr, dis_wr, wr_dr, rd_dr, rd_st2;

  assign pe_wr  = wr_stb_i[RI_CTL] &  wbyte_i[CTL_PE];
  assign dis_wr = wr_stb_i[RI_CTL] & ~wbyte_i[CTL_PE];
  assign wr_dr  = wr_stb_i[RI_DATA];
  assign rd_dr  = rd_stb_i[RI_DATA];
  assign rd_st2 = rd_stb_i[RI_ST2];

  assign set_v = {rx_valid_i, evt_i};

  always_comb begin
    clr_v = {NUM_FLAG{dis_wr}};
    clr_v[EV_START]    |= wr_dr;
    clr_v[EV_HDR10]    |= wr_dr;
    clr_v[EV_TX_DONE]  |= wr_dr;
    clr_v[FL_RX_DONE]  |= rd_dr;
    clr_v[EV_ADDR_END] |= pe_wr;
    clr_v[EV_NACK]     |= rd_st2;
    clr_v[EV_STOP]     |= rd_st2;
    clr_v[EV_ARB]      |= rd_st2;
    clr_v[EV_BUSERR]   |= rd_st2;
    clr_v[EV_SCL_FALL] |= rd_st2;
    clr_v[EV_DDC]      |= rd_st2;
  end

  for (genvar g = 0; g < NUM_FLAG; g++) begin : g_flag
    assign flag_d[g] = set_v[g] | (flag_q[g] & ~clr_v[g]);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
      set_v[g] |=> flag_q[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_d;
  end

  assign flags_o    = flag_q;
  assign evf_o      = |flag_q;
  assign evf_next_o = |flag_d;

  p_st2_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_st2 && !set_v[EV_NACK]) |=> !flag_q[EV_NACK]);
  p_dr_write_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_dr && !set_v[EV_TX_DONE]) |=> !flag_q[EV_TX_DONE]);
  p_pe_write_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (pe_wr && !set_v[EV_ADDR_END]) |=> !flag_q[EV_ADDR_END]);
endmodule

// File: rtl/i2c_reg_front.sv
module i2c_reg_front
  import i2c_front_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel_i,
  input  logic                  bus_wr_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic                  irq_o,
  input  logic [NUM_EVT_IN-1:0] eng_evt_i,
  input  logic                  eng_busy_i,
  input  logic                  eng_tx_mode_i,
  input  logic                  eng_master_i,
  input  logic                  rx_valid_i,
  input  logic [REG_W-1:0]      rx_byte_i,
  output logic [REG_W-1:0]      ctl_o,
  output logic [DIV_W-1:0]      div_o,
  output logic                  fast_o,
  output logic [REG_W-1:0]      own_addr1_o,
  output logic [REG_W-1:0]      own_addr2_o,
  output logic [REG_W-1:0]      tx_byte_o,
  output logic                  tx_load_o
);
  localparam int LANES = DATA_W / REG_W;

  logic [NUM_REGS-1:0]            wr_stb, rd_stb;
  logic                           mapped;
  logic [NUM_REGS-1:0][REG_W-1:0] regs, view;
  logic [REG_W-1:0]               ctl_next, rbyte, st1, st2;
  logic [NUM_FLAG-1:0]            fl;
  logic                           evf, evf_next;
  logic [DATA_W-1:0]              rdata_q;
  logic                           irq_q, tx_load_q;

  i2c_front_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_sel_i (bus_sel_i),
    .bus_wr_i  (bus_wr_i),
    .bus_addr_i(bus_addr_i),
    .wr_stb_o  (wr_stb),
    .rd_stb_o  (rd_stb),
    .mapped_o  (mapped)
  );

  i2c_front_cfg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_stb_i  (wr_stb),
    .wbyte_i   (bus_wdata_i[REG_W-1:0]),
    .rx_valid_i(rx_valid_i),
    .rx_byte_i (rx_byte_i),
    .regs_o    (regs),
    .ctl_next_o(ctl_next)
  );

  i2c_front_events u_events (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (eng_evt_i),
    .rx_valid_i(rx_valid_i),
    .wr_stb_i  (wr_stb),
    .rd_stb_i  (rd_stb),
    .wbyte_i   (bus_wdata_i[REG_W-1:0]),
    .flags_o   (fl),
    .evf_o     (evf),
    .evf_next_o(evf_next)
  );

  assign st1 = {evf, fl[EV_HDR10], eng_tx_mode_i, eng_busy_i,
                fl[EV_TX_DONE] | fl[FL_RX_DONE], fl[EV_ADDR_HIT],
                eng_master_i, fl[EV_START]};
  assign st2 = {fl[EV_SCL_FALL], 1'b0, fl[EV_ADDR_END], fl[EV_NACK],
                fl[EV_STOP], fl[EV_ARB], fl[EV_BUSERR], fl[EV_DDC]};

  always_comb begin
    view         = regs;
    view[RI_ST1] = st1;
    view[RI_ST2] = st2;
    rbyte        = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_stb[i]) rbyte |= view[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      irq_q     <= 1'b0;
      tx_load_q <= 1'b0;
    end else begin
      if (bus_sel_i && !bus_wr_i) rdata_q <= {LANES{rbyte}};
      irq_q     <= evf_next & ctl_next[CTL_IE];
      tx_load_q <= wr_stb[RI_DATA];
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;
  assign tx_load_o   = tx_load_q;
  assign ctl_o       = regs[RI_CTL];
  assign div_o       = {regs[RI_XCLK][XCLK_DIV_W-1:0], regs[RI_CLK][CLK_DIV_W-1:0]};
  assign fast_o      = regs[RI_CLK][CLK_FAST];
  assign own_addr1_o = regs[RI_OWN1];
  assign own_addr2_o = regs[RI_OWN2];
  assign tx_byte_o   = regs[RI_DATA];

  p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (evf && ctl_o[CTL_IE]));
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel_i && !bus_wr_i && !mapped) |=> (bus_rdata_o == '0));
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stb, rd_stb}));
endmodule

// File: tb/test_i2c_reg_front.sv
`timescale 1ns/1ps
module test_i2c_reg_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [10:0] eng_evt = '0;
  logic        eng_busy = 1'b0, eng_tx = 1'b0, eng_master = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [7:0]  ctl, own1, own2, tx_byte;
  logic [11:0] div;
  logic        fast, tx_load;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  i2c_reg_front i_i2c_reg_front (
    .clk(clk), .rst(rst),
    .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq),
    .eng_evt_i(eng_evt), .eng_busy_i(eng_busy), .eng_tx_mode_i(eng_tx),
    .eng_master_i(eng_master), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .ctl_o(ctl), .div_o(div), .fast_o(fast), .own_addr1_o(own1),
    .own_addr2_o(own2), .tx_byte_o(tx_byte), .tx_load_o(tx_load)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rep(logic [7:0] b);
    return {4{b}};
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(logic [10:0] m);
    @(negedge clk);
    eng_evt = m;
    @(negedge clk);
    eng_evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1", "irq after reset", {31'd0, irq}, 32'd0);
    check("R1", "rdata after reset", bus_rdata, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 4), d);
      check("R1", $sformatf("reset value @%0h", i * 4), d, (i == 5) ? rep(8'h40) : 32'd0);
    end
  endtask

  task automatic t_config_rw;
    logic [31:0] d;
    wr(8'h00, 32'hDEADBE21);
    wr(8'h0C, 32'h12345685);
    wr(8'h1C, 32'hFFFFFF1F);
    wr(8'h10, 32'h0000005A);
    wr(8'h14, 32'h000000A6);
    rd(8'h00, d);
    check("R2", "control readback in all lanes", d, rep(8'h21));
    rd(8'h0C, d);
    check("R2", "clock readback", d, rep(8'h85));
    check("R13", "divider value", {20'd0, div}, 32'hF85);
    check("R13", "fast select", {31'd0, fast}, 32'd1);
    check("R2", "own address outputs", {16'd0, own1, own2}, 32'h5AA6);
    wr(8'h18, 32'h0000003C);
    check("R14", "tx_load after data write", {23'd0, tx_load, tx_byte}, 32'h13C);
    @(negedge clk);
    check("R14", "tx_load one cycle only", {31'd0, tx_load}, 32'd0);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'hA5;
    @(negedge clk);
    rx_valid = 1'b0;
    check("R7", "irq on received byte", {31'd0, irq}, 32'd1);
    rd(8'h18, d);
    check("R14", "received byte in data register", d, rep(8'hA5));
    check("R8", "data read clears rx flag and irq", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h00, 32'h21);
    pulse(11'h020);                         // ack failure
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'h01, 32'h00000000);                // misaligned, not control
    rd(8'h20, d);
    check("R3", "unmapped read is zero", d, 32'd0);
    rd(8'h0A, d);
    check("R3", "misaligned read is zero", d, 32'd0);
    check("R3", "irq still pending", {31'd0, irq}, 32'd1);
    rd(8'h00, d);
    check("R3", "control untouched", d, rep(8'h21));
    rd(8'h08, d);
    check("R10", "status 2 returns pre-clear value", d, rep(8'h10));
    rd(8'h08, d);
    check("R10", "status 2 cleared by read", d, 32'd0);
    check("R7", "irq drops after clear", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_status1;
    logic [31:0] d;
    wr(8'h00, 32'h20);
    @(negedge clk);
    eng_busy = 1'b1; eng_tx = 1'b1; eng_master = 1'b1;
    pulse(11'h007);
    rd(8'h04, d);
    check("R4", "status 1 layout", d, rep(8'hF7));
    check("R7", "irq masked with enable clear", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'h21);
    check("R7", "irq with enable set", {31'd0, irq}, 32'd1);
    wr(8'h18, 32'h00);
    rd(8'h04, d);
    check("R8", "data write clears start and header", d, rep(8'hB6));
    wr(8'h00, 32'h21);
    rd(8'h04, d);
    check("R9", "enable write keeps address hit", d, rep(8'hB6));
    wr(8'h00, 32'h00);
    rd(8'h04, d);
    check("R9", "disable write clears all flags", d, rep(8'h32));
    check("R6", "event flag and irq low", {31'd0, irq}, 32'd0);
    @(negedge clk);
    eng_busy = 1'b0; eng_tx = 1'b0; eng_master = 1'b0;
  endtask

  task automatic t_tx_byte;
    logic [31:0] d;
    wr(8'h00, 32'h21);
    pulse(11'h008);
    rd(8'h04, d);
    check("R6", "tx byte flag sets event", d, rep(8'h88));
    rd(8'h18, d);
    rd(8'h04, d);
    check("R8", "data read leaves tx flag", d, rep(8'h88));
    wr(8'h18, 32'h55);
    rd(8'h04, d);
    check("R8", "data write clears tx flag", d, 32'd0);
    check("R7", "irq low after tx clear", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_status2;
    logic [31:0] d;
    wr(8'h00, 32'h20);
    pulse(11'h7F0);
    wr(8'h08, 32'hFFFFFFFF);
    wr(8'h04, 32'h00000000);
    rd(8'h08, d);
    check("R5", "status 2 layout after status writes", d, rep(8'hBF));
    check("R12", "status writes ignored", d, rep(8'hBF));
    rd(8'h08, d);
    check("R10", "end of address survives read", d, rep(8'h20));
    rd(8'h04, d);
    check("R6", "event flag from end of address", d, rep(8'h80));
    wr(8'h00, 32'h20);
    rd(8'h08, d);
    check("R9", "enable write clears end of address", d, 32'd0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(8'h00, 32'h20);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h08; eng_evt = 11'h020;
    @(negedge clk);
    bus_sel = 1'b0; eng_evt = '0;
    check("R11", "read before coincident set", bus_rdata, 32'd0);
    rd(8'h08, d);
    check("R11", "coincident set kept", d, rep(8'h10));
    pulse(11'h040);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h08; eng_evt = 11'h040;
    @(negedge clk);
    bus_sel = 1'b0; eng_evt = '0;
    check("R11", "read sees earlier stop", bus_rdata, rep(8'h08));
    rd(8'h08, d);
    check("R11", "re-set stop survives read", d, rep(8'h08));
    wr(8'h00, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_config_rw();
    t_unmapped();
    t_status1();
    t_tx_byte();
    t_status2();
    t_collide();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL all watchdog: actual running expected done");
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule